// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-clock synchronous SRAM with a two-bit linear burst counter. Each word is 36 bits wide and is split into four 9-bit byte lanes. A new address enters through either of two active-low address strobes, which differ in how they treat the write controls. On the processor-side strobe, the write controls are ignored, so any write follows on later cycles. On the controller-side strobe, the write happens at once at the new address. After a load, the active-low advance input steps the two low address bits through the burst. Holding advance high suspends the burst.

Reads go through one output register. The word at an address appears in the cycle after that address is registered. The output is marked high-impedance, and driven to zero, whenever the output enable is high or no burst is active. Three chip enables select the device. An address strobe seen while the device is not selected ends the current burst. The depth is set by the address-width parameter, so the full array can be shrunk for simulation.

Top module: `sbsram_core`

## Requirements
- R1: The device is selected only when `ce_n` = 0, `ce2_n` = 0 and `ce3` = 1. A strobe that arrives while the device is not selected loads no address and writes nothing.
- R2: When `ads_cpu_n` = 0 and the device is selected, `addr` is loaded and all write controls are ignored in that cycle. This holds even when `ads_ctl_n` is also low, because this strobe takes priority.
- R3: When `ads_ctl_n` = 0, `ads_cpu_n` = 1 and the device is selected, `addr` is loaded, a burst starts or restarts, and the write controls of that cycle write at `addr`.
- R4: In a cycle with no strobe while a burst is active, `adv_n` = 0 moves the address to the next burst address. Only bits [1:0] change, in the order 00, 01, 10, 11, 00. The upper bits stay fixed.
- R5: In a cycle with no strobe, `adv_n` = 1 keeps the address. A write in that cycle goes to the loaded or current address.
- R6: A full 36-bit write happens when `gw_n` = 0, whatever `bwe_n` and `bw_n` are. It also happens when `gw_n` = 1, `bwe_n` = 0 and `bw_n` = 4'b0000.
- R7: When `gw_n` = 1 and `bwe_n` = 0, only the lanes with `bw_n[i]` = 0 are written, where lane i is data bits [9i+8:9i]. The other lanes keep their contents. When `gw_n` = 1 and `bwe_n` = 1, nothing is written.
- R8: After the clock edge that sets the address to X, `rdata` shows the word stored at X before any write made at that same edge. Each advance then shows the next burst word one cycle later.
- R9: While `oe_n` = 1, `rdata_hiz` = 1 in the same cycle. Whenever `rdata_hiz` = 1, `rdata` = 0.
- R10: A strobe while the device is not selected ends the burst, so `rdata_hiz` = 1 from the next cycle. While no burst is active, cycles without a strobe write nothing.
- R11: Reset clears the burst state, so `rdata_hiz` = 1. Reset leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the burst state |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce3 | input | 1 | Third chip enable, active high |
| ads_cpu_n | input | 1 | Processor-side address strobe, active low, ignores the write controls |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low, honours the write controls |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero when high-impedance |
| rdata_hiz | output | 1 | High when the read port would not be driven |

## Verification
The bound checker tests several properties on every cycle:
- the output-enable and deselect paths to high-impedance;
- that the processor-side strobe, a deselected strobe and an idle device produce no lane writes;
- that the address is captured on the processor-side strobe;
- that the address holds while advance is high, and that the upper address bits never move between strobes.

Other behaviour shows only in the bench's scenarios, where a behavioural model predicts every output word:
- the real contents of the lanes after mixed global, full and partial byte writes;
- the wrap order of the burst;
- the one-cycle read latency, including reads that collide with writes;
- that the stored words survive a reset.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

   // Kind of cycle decoded from the enables and strobes.
   typedef enum logic [2:0] {
      CY_IDLE,    // no strobe, no burst active
      CY_DESEL,   // strobe while not selected: burst ends
      CY_LOAD_P,  // processor-side load, write controls ignored
      CY_LOAD_C,  // controller-side load, write honoured
      CY_CONT     // no strobe, burst active: hold or advance
   } cyc_e;

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
   import sbsram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             ce_n,
   input  logic             ce2_n,
   input  logic             ce3,
   input  logic             ads_cpu_n,
   input  logic             ads_ctl_n,
   input  logic             live_q,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output cyc_e             cyc,
   output logic [LANES-1:0] lane_we
);

   logic             selected;
   logic [LANES-1:0] lane_req;

   assign selected = !ce_n && !ce2_n && ce3;

   always_comb begin
      if (!ads_cpu_n || !ads_ctl_n) begin
         if (!selected)       cyc = CY_DESEL;
         else if (!ads_cpu_n) cyc = CY_LOAD_P;
         else                 cyc = CY_LOAD_C;
      end else begin
         cyc = live_q ? CY_CONT : CY_IDLE;
      end
   end

   // Global write overrides the byte path.
   always_comb begin
      if (!gw_n)       lane_req = '1;
      else if (!bwe_n) lane_req = ~bw_n;
      else             lane_req = '0;
   end

   assign lane_we = (cyc == CY_LOAD_C || cyc == CY_CONT) ? lane_req : '0;

endmodule

// File: rtl/sbsram_addr.sv
module sbsram_addr
   import sbsram_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] cur_q,
   output logic [ADDR_W-1:0] nxt,
   output logic              live_q
);

   localparam logic [BURST_BITS-1:0] STEP = BURST_BITS'(1);

   always_comb begin
      nxt = cur_q;
      case (cyc)
         CY_LOAD_P, CY_LOAD_C: nxt = addr;
         CY_CONT: if (!adv_n) nxt[BURST_BITS-1:0] = cur_q[BURST_BITS-1:0] + STEP;
         default: nxt = cur_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         live_q <= 1'b0;
      end else begin
         cur_q <= nxt;
         if (cyc == CY_LOAD_P || cyc == CY_LOAD_C) live_q <= 1'b1;
         else if (cyc == CY_DESEL)                 live_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sbsram_store.sv
module sbsram_store #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rword_q
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      // The read register samples the word as it was before this edge's write.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rword_q[g*LANE_W +: LANE_W] <= '0;
         else        rword_q[g*LANE_W +: LANE_W] <= mem[raddr];
      end
   end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
   import sbsram_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2,
   parameter int DATA_W     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              ce2_n,
   input  logic              ce3,
   input  logic              ads_cpu_n,
   input  logic              ads_ctl_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_hiz
);

   if (DATA_W != LANES * LANE_W) begin : g_bad_width
      $error("sbsram_core: DATA_W must equal LANES*LANE_W");
   end
   if (BURST_BITS < 1 || BURST_BITS >= ADDR_W) begin : g_bad_burst
      $error("sbsram_core: BURST_BITS must be in 1..ADDR_W-1");
   end

   cyc_e              cyc;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] nxt;
   logic              live_q;
   logic [DATA_W-1:0] rword_q;

   sbsram_ctrl #(.LANES(LANES)) u_ctrl (
      .ce_n(ce_n), .ce2_n(ce2_n), .ce3(ce3),
      .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .live_q(live_q),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
      .cyc(cyc), .lane_we(lane_we)
   );

   sbsram_addr #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_addr (
      .clk(clk), .rst_n(rst_n), .cyc(cyc), .adv_n(adv_n), .addr(addr),
      .cur_q(cur_q), .nxt(nxt), .live_q(live_q)
   );

   // Writes and the read register both target the next address.
   sbsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .waddr(nxt),
      .wdata(wdata), .raddr(nxt), .rword_q(rword_q)
   );

   assign rdata_hiz = oe_n || !live_q;
   assign rdata     = rdata_hiz ? '0 : rword_q;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
   parameter int ADDR_W     = 8,
   parameter int LANES      = 4,
   parameter int BURST_BITS = 2,
   parameter int DATA_W     = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              ce2_n,
   input logic              ce3,
   input logic              ads_cpu_n,
   input logic              ads_ctl_n,
   input logic              adv_n,
   input logic [ADDR_W-1:0] addr,
   input logic              oe_n,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_hiz,
   input logic [ADDR_W-1:0] cur_q,
   input logic              live_q,
   input logic [LANES-1:0]  lane_we
);

   logic sel, any_strb;
   assign sel      = !ce_n && !ce2_n && ce3;
   assign any_strb = !ads_cpu_n || !ads_ctl_n;

   assert_oe_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> rdata_hiz);
   assert_hiz_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_hiz |-> rdata == '0);
   assert_desel_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (any_strb && !sel) |=> rdata_hiz);
   assert_desel_nowr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (any_strb && !sel) |-> lane_we == '0);
   assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_cpu_n && sel) |=> cur_q == $past(addr));
   assert_cpu_nowr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_cpu_n && sel) |-> lane_we == '0);
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_strb && adv_n) |=> $stable(cur_q));
   assert_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !any_strb |=> cur_q[ADDR_W-1:BURST_BITS] == $past(cur_q[ADDR_W-1:BURST_BITS]));
   assert_idle_nowr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_strb && !live_q) |-> lane_we == '0);

endmodule

bind sbsram_core sbsram_chk #(
   .ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2_n(ce2_n), .ce3(ce3),
   .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .addr(addr),
   .oe_n(oe_n), .rdata(rdata), .rdata_hiz(rdata_hiz),
   .cur_q(cur_q), .live_q(live_q), .lane_we(lane_we)
);

// File: tb/sim_sbsram_core.sv
`timescale 1ns/1ps
module sim_sbsram_core;
   localparam int AW = 8;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN * LW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, ce_n, ce2_n, ce3, ads_cpu_n, ads_ctl_n, adv_n;
   logic gw_n, bwe_n, oe_n, rdata_hiz;
   logic [AW-1:0] addr;
   logic [LN-1:0] bw_n;
   logic [DW-1:0] wdata, rdata;

   sbsram_core u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2_n(ce2_n), .ce3(ce3),
      .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .addr(addr),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata),
      .rdata(rdata), .rdata_hiz(rdata_hiz)
   );

   int vecs = 0;
   int bad  = 0;

   // Behavioural reference state.
   logic [DW-1:0] mmem [0:(1<<AW)-1];
   logic [AW-1:0] mcur;
   logic          mlive;
   logic [DW-1:0] mrd;

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(a) * 36'd2654435 + 36'h3C3;
   endfunction

   task automatic model_step();
      logic          selv;
      logic [AW-1:0] nx;
      logic [LN-1:0] req, we;
      if (!rst_n) begin
         mlive = 1'b0; mcur = '0; mrd = '0;
         return;
      end
      selv = !ce_n && !ce2_n && ce3;
      nx   = mcur;
      we   = '0;
      req  = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
      if (!ads_cpu_n || !ads_ctl_n) begin
         if (!selv) mlive = 1'b0;
         else if (!ads_cpu_n) begin nx = addr; mlive = 1'b1; end
         else begin nx = addr; mlive = 1'b1; we = req; end
      end else if (mlive) begin
         we = req;
         if (!adv_n) nx[1:0] = nx[1:0] + 2'd1;
      end
      mrd = mmem[nx];
      for (int i = 0; i < LN; i++)
         if (we[i]) mmem[nx][i*LW +: LW] = wdata[i*LW +: LW];
      mcur = nx;
   endtask

   task automatic check(input string tag);
      logic          eh;
      logic [DW-1:0] ed;
      eh = oe_n || !mlive;
      ed = eh ? '0 : mrd;
      vecs++;
      if (rdata_hiz !== eh || rdata !== ed) begin
         bad++;
         $display("FAIL %s: hiz=%0b rdata=%h, expected hiz=%0b rdata=%h",
                  tag, rdata_hiz, rdata, eh, ed);
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag);
   endtask

   task automatic quiet();
      ads_cpu_n = 1'b1; ads_ctl_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ce_n = 1'b0; ce2_n = 1'b0; ce3 = 1'b1; oe_n = 1'b1;
      addr = '0; wdata = '0; quiet();
      mlive = 1'b0; mcur = '0; mrd = '0;
      repeat (3) tick("R11 reset");
      rst_n = 1'b1;
      tick("R11 after reset");

      // Fill the array: a controller-side write burst per block of four.
      for (int b = 0; b < (1 << AW); b += 4) begin
         ads_ctl_n = 1'b0; addr = AW'(b); gw_n = 1'b0; wdata = pat(b);
         tick("R3 fill");
         ads_ctl_n = 1'b1; adv_n = 1'b0;
         for (int k = 1; k < 4; k++) begin
            wdata = pat(b + k);
            tick("R4 fill");
         end
         quiet();
      end

      // Read burst from a mid-block address, with wrap.
      oe_n = 1'b0;
      ads_cpu_n = 1'b0; addr = 8'h16;
      tick("R8 load read");
      ads_cpu_n = 1'b1; adv_n = 1'b0;
      repeat (4) tick("R4 burst wrap");
      adv_n = 1'b1;
      repeat (2) tick("R5 suspend");
      adv_n = 1'b0;
      tick("R4 resume");

      // Both strobes low with a global write: processor strobe wins, no write.
      quiet(); ads_cpu_n = 1'b0; ads_ctl_n = 1'b0; addr = 8'h20;
      gw_n = 1'b0; wdata = 36'h0_DEAD_BEEF;
      tick("R2 priority");
      quiet();
      tick("R2 no write");
      // Partial byte write to the loaded address.
      oe_n = 1'b1; bwe_n = 1'b0; bw_n = 4'b1010; wdata = 36'hF_FFFF_FFFF;
      tick("R9 oe high");
      quiet(); oe_n = 1'b0;
      tick("R7 collide");
      tick("R7 lanes");
      // Byte-write enable high with all lane strobes low: no write.
      bw_n = 4'b0000; wdata = 36'h1_2345_6789;
      tick("R7 no bwe");
      quiet();
      tick("R7 kept");

      // Global write with byte path off, then full write via byte path.
      oe_n = 1'b1;
      ads_ctl_n = 1'b0; addr = 8'h31; gw_n = 1'b0; bw_n = '1;
      wdata = 36'hA_AAAA_5555;
      tick("R6 global");
      ads_ctl_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b0; bw_n = 4'b0000;
      adv_n = 1'b0; wdata = 36'h5_5555_AAAA;
      tick("R6 all lanes");
      quiet(); adv_n = 1'b0; bw_n = 4'b0000; wdata = 36'h0;
      tick("R7 bwe high");
      quiet(); oe_n = 1'b0;
      ads_cpu_n = 1'b0; addr = 8'h30;
      tick("R8 readback");
      ads_cpu_n = 1'b1; adv_n = 1'b0;
      tick("R8 word1");
      tick("R6 word2");
      // Controller strobe restarts the burst mid-read.
      ads_ctl_n = 1'b0; adv_n = 1'b1; addr = 8'h47;
      tick("R3 restart");
      ads_ctl_n = 1'b1; adv_n = 1'b0;
      tick("R4 wrap from 3");
      oe_n = 1'b1;
      tick("R9 oe mid burst");
      oe_n = 1'b0;
      tick("R9 oe back");

      // Deselect through each enable, with a write attempted.
      for (int v = 0; v < 3; v++) begin
         quiet();
         ce_n = (v == 0); ce2_n = (v == 1); ce3 = (v != 2);
         ads_ctl_n = 1'b0; addr = 8'h50; gw_n = 1'b0; wdata = 36'h9_9999_9999;
         tick("R1 deselected strobe");
         ce_n = 1'b0; ce2_n = 1'b0; ce3 = 1'b1; ads_ctl_n = 1'b1;
         tick("R10 idle no write");
         quiet(); ads_cpu_n = 1'b0; addr = 8'h50;
         tick("R1 reload");
         quiet();
         tick("R1 check word");
      end
      quiet(); ce3 = 1'b0; ads_cpu_n = 1'b0; addr = 8'h60;
      tick("R1 cpu deselect");
      quiet(); ce3 = 1'b1;
      tick("R10 stays hiz");

      // Reset mid-run keeps the contents.
      ads_cpu_n = 1'b0; addr = 8'h20;
      tick("R8 pre reset");
      quiet(); rst_n = 1'b0;
      tick("R11 mid reset");
      rst_n = 1'b1;
      tick("R11 idle");
      ads_cpu_n = 1'b0; addr = 8'h21;
      tick("R11 contents kept");
      quiet();
      tick("R11 hold");

      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule